// File: doc/BRIEF.md
# Flash Prefetch Bus Interface

This block stands between a system-bus read port and the read port of a flash array controller. Each bus read is answered either from one of a small set of line-wide prefetch buffers, with no wait states, or by an array access whose length is set by a programmable wait-state count. After a demand miss, if prefetching is enabled for the access type, the block reads the next sequential line into a second buffer while the processor uses the first.

A six-bit configuration register holds the wait-state count and two prefetch enables, one for instruction fetches and one for data reads. Each write carries an origin flag. A write flagged as coming from code that runs out of the flash array is dropped. Any write that is accepted clears every prefetch buffer.

The bus request side uses a valid/ready handshake. `req_ready` is high only while no array access is in flight. A requester that sees it low must hold `req_valid`, `req_addr` and `req_instr` steady until the transfer is accepted. Only one request is outstanding at a time. There is no back-pressure on the read data: `rd_valid` is a single-cycle pulse that must be taken when it appears. The array port presents a line address on `arr_addr` while `arr_rd` is high, and samples `arr_rdata` in the access's last cycle.

Top module: `flash_pf_biu`

## Requirements
- R1: Out of reset, `cfg_rdata` reads 0x0F (wait field 15, both prefetch enables 0), `req_ready` is 1, and `rd_valid` and `arr_rd` are 0.
- R2: A read that hits a valid buffer line pulses `rd_valid` in the cycle right after acceptance, and does not raise `arr_rd`.
- R3: On a miss with wait field N, `arr_rd` stays high for exactly N+1 cycles, and `rd_valid` pulses N+2 cycles after the accepting edge.
- R4: An accepted configuration write loads `cfg_wdata` on the next edge. Bits [3:0] are the wait count, bit 4 enables instruction prefetch, and bit 5 enables data prefetch. The stored value is visible on `cfg_rdata`.
- R5: A configuration write with `cfg_wr_from_flash`=1 changes neither `cfg_rdata` nor the buffer contents.
- R6: When prefetch is enabled for the access type (`req_instr`=1 selects instruction, 0 selects data), a demand miss to line L is followed at once by an N+1-cycle array read of line L+1. A later read of line L+1 then hits.
- R7: When prefetch is disabled for the access type, no array read follows the demand miss.
- R8: No prefetch is issued when line L+1 is already in a buffer.
- R9: An accepted configuration write invalidates all buffers, so that a line that hit before now misses.
- R10: While an array access is in flight, `req_ready` is 0 and `arr_addr` holds steady. A request that arrives during a prefetch waits until the prefetch fills its buffer.
- R11: A fill replaces the least recently used buffer. A hit counts as a use.
- R12: Each accepted request produces exactly one single-cycle `rd_valid` pulse. `rd_data` is 32-bit word `req_addr[3:2]` of the 16-byte line `req_addr[23:4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Byte address of the read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| rd_valid | output | 1 | Read data pulse, one per request |
| rd_data | output | 32 | Read data word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_from_flash | input | 1 | Write issued by code running from flash |
| cfg_wdata | input | 6 | Configuration write value |
| cfg_rdata | output | 6 | Current configuration value |
| arr_rd | output | 1 | Array access in progress |
| arr_addr | output | 20 | Line address presented to the array |
| arr_rdata | input | 128 | Line data from the array |

## Verification
The bench times a miss at the reset wait count and again at a small count. An off-by-one counter would shift the data pulse or stretch `arr_rd`. It sends a request during a prefetch and checks that the request stalls for exactly the prefetch length and then hits; a design that re-issued the array early, or forgot the prefetched line, would miss. It checks that a prefetch follows a miss only for the enabled access type, and that no prefetch is issued when the next line is already held; an extra array read would show in the `arr_rd` cycle count. It also checks the write lock and the invalidate on reconfiguration, and fills a third line after re-touching the first, so that a victim choice that ignored hits would evict the wrong line.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  localparam int CFG_W = 6;

  typedef struct packed {
    logic       dpf_en;
    logic       ipf_en;
    logic [3:0] ws;
  } fpb_cfg_t;

  localparam fpb_cfg_t CFG_RESET = '{dpf_en: 1'b0, ipf_en: 1'b0, ws: 4'hF};

  typedef enum logic [1:0] {ST_IDLE, ST_DEMAND, ST_PREF} fpb_state_e;
endpackage

// File: rtl/fpb_cfg_reg.sv
module fpb_cfg_reg
  import fpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_from_flash,
  input  logic [CFG_W-1:0] wr_data,
  output fpb_cfg_t         cfg,
  output logic             wr_taken
);
  assign wr_taken = wr_en && !wr_from_flash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= CFG_RESET;
    else if (wr_taken) cfg <= fpb_cfg_t'(wr_data);
  end

  p_flash_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_from_flash |=> $stable(cfg));
  p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_taken |=> cfg == fpb_cfg_t'($past(wr_data)));
endmodule

// File: rtl/fpb_wait_ctr.sv
module fpb_wait_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          cancel,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (cancel) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) && !cancel |=> busy);
endmodule

// File: rtl/fpb_line_buf.sv
module fpb_line_buf #(
  parameter int NBUF   = 2,
  parameter int LA_W   = 20,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LA_W-1:0]   lk_line,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_data,
  input  logic [LA_W-1:0]   pr_line,
  output logic              pr_hit,
  input  logic              touch,
  input  logic              fill,
  input  logic [LA_W-1:0]   fill_line,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              inv_all
);
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1;

  logic [LA_W-1:0]   tag [NBUF];
  logic [LINE_W-1:0] dat [NBUF];
  logic [IDX_W-1:0]  age [NBUF];
  logic [NBUF-1:0]   vld, lk_vec, pr_vec;
  logic [IDX_W-1:0]  lk_idx, vic, upd_idx;
  logic              upd_en;

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    assign lk_vec[g] = vld[g] && (tag[g] == lk_line);
    assign pr_vec[g] = vld[g] && (tag[g] == pr_line);
  end

  assign lk_hit = |lk_vec;
  assign pr_hit = |pr_vec;

  always_comb begin
    lk_data = '0;
    lk_idx  = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (lk_vec[i]) begin
        lk_data = lk_data | dat[i];
        lk_idx  = IDX_W'(i);
      end
    end
  end

  // victim: lowest invalid entry, otherwise the oldest one
  always_comb begin
    logic found;
    found = 1'b0;
    vic   = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (!vld[i] && !found) begin
        vic   = IDX_W'(i);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NBUF; i++)
        if (age[i] == IDX_W'(NBUF - 1)) vic = IDX_W'(i);
    end
  end

  assign upd_en  = (fill && !inv_all) || (touch && lk_hit);
  assign upd_idx = fill ? vic : lk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < NBUF; i++) begin
        tag[i] <= '0;
        dat[i] <= '0;
        age[i] <= IDX_W'(i);
      end
    end else begin
      if (inv_all) begin
        vld <= '0;
      end else if (fill) begin
        vld[vic] <= 1'b1;
        tag[vic] <= fill_line;
        dat[vic] <= fill_data;
      end
      if (upd_en) begin
        for (int i = 0; i < NBUF; i++) begin
          if (IDX_W'(i) == upd_idx)      age[i] <= '0;
          else if (age[i] < age[upd_idx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  p_tag_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));
  p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0));
endmodule

// File: rtl/flash_pf_biu.sv
module flash_pf_biu
  import fpb_pkg::*;
#(
  parameter  int AW     = 24,
  parameter  int DW     = 32,
  parameter  int LINE_W = 128,
  parameter  int NBUF   = 2,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int LA_W   = AW - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_instr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic              cfg_wr,
  input  logic              cfg_wr_from_flash,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              arr_rd,
  output logic [LA_W-1:0]   arr_addr,
  input  logic [LINE_W-1:0] arr_rdata
);
  localparam int WPL    = LINE_W / DW;
  localparam int BOFF_W = $clog2(DW / 8);
  localparam int WSEL_W = (WPL > 1) ? $clog2(WPL) : 1;

  fpb_cfg_t          cfg;
  logic              cfg_taken;
  fpb_state_e        state;
  logic [LA_W-1:0]   cur_line, req_line;
  logic [WSEL_W-1:0] cur_word, req_word;
  logic              cur_instr;
  logic              acc, lk_hit, pr_hit, pf_allowed, go_pf;
  logic [LINE_W-1:0] lk_data;
  logic              ctr_load, ctr_cancel, ctr_busy, ctr_done;

  function automatic logic [DW-1:0] pick(input logic [LINE_W-1:0] ln,
                                         input logic [WSEL_W-1:0] w);
    return ln[w*DW +: DW];
  endfunction

  assign req_line = req_addr[AW-1:OFF_W];
  if (WPL > 1) begin : g_wsel
    assign req_word = req_addr[OFF_W-1:BOFF_W];
  end else begin : g_wone
    assign req_word = '0;
  end

  assign req_ready  = (state == ST_IDLE);
  assign acc        = req_valid && req_ready;
  assign pf_allowed = cur_instr ? cfg.ipf_en : cfg.dpf_en;
  assign go_pf      = pf_allowed && !pr_hit && !cfg_taken;
  assign arr_rd     = ctr_busy;
  assign arr_addr   = (state == ST_PREF) ? cur_line + 1'b1 : cur_line;
  assign cfg_rdata  = cfg;
  assign ctr_load   = (acc && !lk_hit) || (state == ST_DEMAND && ctr_done && go_pf);
  assign ctr_cancel = cfg_taken && (state == ST_PREF);

  fpb_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_from_flash(cfg_wr_from_flash),
    .wr_data(cfg_wdata), .cfg(cfg), .wr_taken(cfg_taken)
  );

  fpb_wait_ctr #(.CW(4)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(cfg.ws),
    .cancel(ctr_cancel), .busy(ctr_busy), .done(ctr_done)
  );

  fpb_line_buf #(.NBUF(NBUF), .LA_W(LA_W), .LINE_W(LINE_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .lk_line(req_line), .lk_hit(lk_hit), .lk_data(lk_data),
    .pr_line(cur_line + 1'b1), .pr_hit(pr_hit),
    .touch(acc), .fill(ctr_done && !cfg_taken), .fill_line(arr_addr),
    .fill_data(arr_rdata), .inv_all(cfg_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_line  <= '0;
      cur_word  <= '0;
      cur_instr <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (acc) begin
          if (lk_hit) begin
            rd_valid <= 1'b1;
            rd_data  <= pick(lk_data, req_word);
          end else begin
            state     <= ST_DEMAND;
            cur_line  <= req_line;
            cur_word  <= req_word;
            cur_instr <= req_instr;
          end
        end
        ST_DEMAND: if (ctr_done) begin
          rd_valid <= 1'b1;
          rd_data  <= pick(arr_rdata, cur_word);
          state    <= go_pf ? ST_PREF : ST_IDLE;
        end
        ST_PREF: if (cfg_taken || ctr_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_hit_no_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && lk_hit |=> rd_valid && !arr_rd);
  p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd |-> !req_ready);
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd && !ctr_done && !cfg_taken |=> $stable(arr_addr));
  p_pf_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEMAND) && ctr_done && !pf_allowed |=> !arr_rd);
endmodule

// File: tb/flash_pf_biu_tb_top.sv
`timescale 1ns/1ps
module flash_pf_biu_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_instr = 1'b0;
  logic [23:0]  req_addr = '0;
  logic         req_ready, rd_valid;
  logic [31:0]  rd_data;
  logic         cfg_wr = 1'b0, cfg_wr_from_flash = 1'b0;
  logic [5:0]   cfg_wdata = '0;
  logic [5:0]   cfg_rdata;
  logic         arr_rd;
  logic [19:0]  arr_addr;
  logic [127:0] arr_rdata;

  int vecs = 0, bad = 0, nreads = 0, arr_cyc = 0, rdv_cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_pf_biu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_instr(req_instr), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_wr(cfg_wr), .cfg_wr_from_flash(cfg_wr_from_flash), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] model_word(input logic [19:0] la, input int w);
    return {4'hA, 2'(w), 6'h0, la};
  endfunction

  always_comb
    for (int w = 0; w < 4; w++) arr_rdata[w*32 +: 32] = model_word(arr_addr, w);

  always @(negedge clk) if (rst_n) begin
    if (arr_rd)   arr_cyc++;
    if (rd_valid) rdv_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [23:0] a, input bit instr,
                         output int waited, output int lat, output logic [31:0] d);
    req_addr = a; req_instr = instr; req_valid = 1'b1; waited = 0;
    while (!req_ready) begin @(posedge clk); @(negedge clk); waited++; end
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; lat = 1;
    while (!rd_valid) begin @(posedge clk); @(negedge clk); lat++; end
    d = rd_data; nreads++;
  endtask

  task automatic cfg_write(input logic [5:0] v, input bit from_flash);
    cfg_wdata = v; cfg_wr_from_flash = from_flash; cfg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0; cfg_wr_from_flash = 1'b0;
  endtask

  function automatic logic [31:0] expw(input logic [23:0] a);
    return model_word(a[23:4], int'(a[3:2]));
  endfunction

  // helper: read and check latency, stall count and data
  task automatic rd_chk(input logic [23:0] a, input bit instr, input int exp_lat,
                        input int exp_wait, input string req);
    int w, l; logic [31:0] d;
    do_read(a, instr, w, l, d);
    chk(l == exp_lat, req, "latency", l, exp_lat);
    if (exp_wait >= 0) chk(w == exp_wait, req, "stall cycles", w, exp_wait);
    chk(d == expw(a), "R12", "read data", d, expw(a));
  endtask

  task automatic t_reset;
    chk(cfg_rdata == 6'h0F, "R1", "cfg after reset", cfg_rdata, 6'h0F);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0 && arr_rd == 1'b0, "R1", "idle outputs", {rd_valid, arr_rd}, 0);
  endtask

  task automatic t_miss_timing;
    int c0;
    c0 = arr_cyc;
    rd_chk(24'h000100, 1'b1, 17, 0, "R3");
    chk(arr_cyc - c0 == 16, "R3", "array cycles ws15", arr_cyc - c0, 16);
    cfg_write(6'h02, 1'b0);
    chk(cfg_rdata == 6'h02, "R4", "cfg write", cfg_rdata, 6'h02);
    c0 = arr_cyc;
    rd_chk(24'h000200, 1'b1, 4, 0, "R3");
    chk(arr_cyc - c0 == 3, "R3", "array cycles ws2", arr_cyc - c0, 3);
  endtask

  task automatic t_hit;
    int c0;
    c0 = arr_cyc;
    rd_chk(24'h000204, 1'b0, 1, 0, "R2");
    chk(arr_cyc == c0, "R2", "no array on hit", arr_cyc - c0, 0);
  endtask

  task automatic t_lock;
    cfg_write(6'h35, 1'b1);
    chk(cfg_rdata == 6'h02, "R5", "locked write ignored", cfg_rdata, 6'h02);
    rd_chk(24'h000208, 1'b1, 1, 0, "R5");
  endtask

  task automatic t_inval;
    cfg_write(6'h02, 1'b0);
    rd_chk(24'h00020C, 1'b1, 4, 0, "R9");
  endtask

  task automatic t_pf_instr;
    int c0;
    cfg_write(6'h12, 1'b0);
    c0 = arr_cyc;
    rd_chk(24'h000400, 1'b1, 4, 0, "R6");
    rd_chk(24'h000414, 1'b1, 1, 3, "R10");
    chk(arr_cyc - c0 == 6, "R6", "demand plus prefetch cycles", arr_cyc - c0, 6);
  endtask

  task automatic t_no_pf;
    rd_chk(24'h000800, 1'b0, 4, 0, "R7");
    rd_chk(24'h000818, 1'b0, 4, 0, "R7");
  endtask

  task automatic t_pf_data;
    cfg_write(6'h22, 1'b0);
    rd_chk(24'h000A00, 1'b0, 4, 0, "R6");
    rd_chk(24'h000A1C, 1'b0, 1, 3, "R6");
    rd_chk(24'h000B00, 1'b1, 4, 0, "R7");
    rd_chk(24'h000B10, 1'b1, 4, 0, "R7");
  endtask

  task automatic t_skip;
    int c0;
    cfg_write(6'h32, 1'b0);
    rd_chk(24'h000C10, 1'b1, 4, 0, "R6");
    rd_chk(24'h000C20, 1'b1, 1, 3, "R6");
    rd_chk(24'h000C14, 1'b1, 1, 0, "R11");
    c0 = arr_cyc;
    rd_chk(24'h000C00, 1'b1, 4, 0, "R8");
    rd_chk(24'h000C18, 1'b1, 1, 0, "R8");
    chk(arr_cyc - c0 == 3, "R8", "no prefetch of held line", arr_cyc - c0, 3);
  endtask

  task automatic t_lru;
    cfg_write(6'h02, 1'b0);
    rd_chk(24'h000E00, 1'b1, 4, 0, "R11");
    rd_chk(24'h000E40, 1'b1, 4, 0, "R11");
    rd_chk(24'h000E04, 1'b1, 1, 0, "R11");
    rd_chk(24'h000E80, 1'b1, 4, 0, "R11");
    rd_chk(24'h000E08, 1'b1, 1, 0, "R11");
    rd_chk(24'h000E4C, 1'b1, 4, 0, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_miss_timing;
    t_hit;
    t_lock;
    t_inval;
    t_pf_instr;
    t_no_pf;
    t_pf_data;
    t_skip;
    t_lru;
    repeat (4) @(negedge clk);
    chk(rdv_cnt == nreads, "R12", "one pulse per request", rdv_cnt, nreads);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule